// File: doc/BRIEF.md
# Key-Protected Dual-Clock Watchdog Timer

This block is a watchdog for a processor subsystem. Software programs a timeout, enables the timer and then has to restart it at regular intervals. If a restart does not arrive before the programmed time runs out, the block sends a one-cycle reset request toward the system reset logic. The timeout is built from a prescaler that feeds a timeout counter. Both count down on an always-on safe clock. A small register bus sets them up and runs on a separate bus clock.

Writes to the control register need a key in the upper data bits. A stray write therefore cannot disable the timer. A debug mode bit turns every timeout into an interrupt event in place of a reset request. A pause bit stalls both counters while the processor's debug-halt input is high. Each command crosses to the safe-clock domain as one snapshot through a toggle handshake. An accepted control write and a restart write are both commands, and each snapshot holds the control bits, the period and the prescale value. A busy bit covers each transfer.

Top module: `keyed_watchdog`

## Requirements
- R1: While the timer is enabled and debug mode is off, reset request pulses repeat every (PRESC+1)×(PERIOD+1) safe-clock cycles. PERIOD is at address 1 and PRESC is at address 2.
- R2: Any write to address 3 (restart) reloads both counters, so restarts issued faster than the timeout keep the reset request low. Once restarts stop, a pulse follows. For any timeout of two or more cycles, each pulse is one safe cycle wide.
- R3: A write to the control register (address 0) counts only when data bits 31:8 equal 0xC3A95E. Any other write there leaves the control readback unchanged, starts no command and has no effect on the timer.
- R4: The control fields are bit 0 enable, bit 1 pause and bit 2 debug mode. In debug mode a timeout never raises the reset request. It sets status bit 0 (address 6), and the irq output is high only when that bit and the interrupt enable (address 4, bit 0) are both set.
- R5: Writing 1 to bit 0 of address 5 clears status bit 0. When a timeout event and a clear reach the status bit in the same bus cycle, the bit stays set.
- R6: While pause is set and dbg_halt is high, both counters hold, so the reset request interval grows by exactly the number of halted safe cycles. With pause clear, dbg_halt has no effect.
- R7: Status bit 1 (busy) goes high when a command is accepted and stays high until the safe domain acknowledges it. While busy, control and restart writes are dropped.
- R8: With enable clear, the counters hold and no reset request is produced.
- R9: After reset, rst_req and irq are low and all registers read zero. The control, period and prescale registers read back the last accepted values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| bus_rst_n | input | 1 | Bus-domain asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one bus cycle per write |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Timeout interrupt, bus domain |
| safe_clk | input | 1 | Always-on counting clock |
| safe_rst_n | input | 1 | Safe-domain asynchronous reset, active low |
| dbg_halt | input | 1 | Processor debug-halt indication |
| rst_req | output | 1 | Reset request pulse, safe domain |

## Verification
Two events can reach the interrupt status bit in the same bus cycle: a timeout event arriving from the safe domain and a software clear write. The bench runs debug mode with a short timeout and enables the interrupt. It then issues clear writes on every bus cycle for a stretch that spans several timeouts, so some clears land on the same cycle as a synchronised event. The bound checker confirms that the bit is set after every such collision. The bench then checks that a later event still sets the bit and that a quiet clear still empties it.

// File: rtl/keyed_wdt_pkg.sv
`timescale 1ns/1ps
package keyed_wdt_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int KEY_W  = 24;
  localparam logic [KEY_W-1:0] CTRL_KEY = 24'hC3A95E;

  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
  localparam logic [ADDR_W-1:0] A_PERIOD  = 3'd1;
  localparam logic [ADDR_W-1:0] A_PRESC   = 3'd2;
  localparam logic [ADDR_W-1:0] A_RESTART = 3'd3;
  localparam logic [ADDR_W-1:0] A_IRQEN   = 3'd4;
  localparam logic [ADDR_W-1:0] A_IRQCLR  = 3'd5;
  localparam logic [ADDR_W-1:0] A_STATUS  = 3'd6;

  // Control word fields, LSB first: enable, pause, debug
  typedef struct packed {
    logic dbg;
    logic pause;
    logic en;
  } wdt_ctrl_t;

  localparam int CTRL_W = $bits(wdt_ctrl_t);
endpackage

// File: rtl/wdk_sync.sv
`timescale 1ns/1ps
// Multi-flop single-bit synchroniser, STAGES >= 2
module wdk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb sr_d = {sr_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/wdk_regs.sv
`timescale 1ns/1ps
// Bus-domain register file, command launcher and interrupt status
module wdk_regs
  import keyed_wdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ack_tgl_s,
  input  logic              ov_tgl_s,
  output logic              req_tgl,
  output wdt_ctrl_t         cmd_ctrl,
  output logic [CNT_W-1:0]  cmd_period,
  output logic [PRE_W-1:0]  cmd_presc,
  output wdt_ctrl_t         ctrl_rb,
  output logic              irq_status,
  output logic              irq_en,
  output logic              ov_evt,
  output logic              clr_hit,
  output logic              irq
);
  wdt_ctrl_t        ctrl_q, ctrl_d;
  logic [CNT_W-1:0] period_q, period_d;
  logic [PRE_W-1:0] presc_q, presc_d;
  wdt_ctrl_t        cmd_ctrl_q, cmd_ctrl_d;
  logic [CNT_W-1:0] cmd_period_q, cmd_period_d;
  logic [PRE_W-1:0] cmd_presc_q, cmd_presc_d;
  logic             req_q, req_d;
  logic             ov_prev_q;
  logic             irq_st_q, irq_st_d;
  logic             irq_en_q, irq_en_d;
  logic             irq_q, irq_d;

  logic busy, key_ok, ctrl_wr, rst_wr, fire;

  assign busy    = req_q ^ ack_tgl_s;
  assign key_ok  = (wdata[DATA_W-1 -: KEY_W] == CTRL_KEY);
  assign ctrl_wr = wr && (addr == A_CTRL) && key_ok;
  assign rst_wr  = wr && (addr == A_RESTART);
  assign fire    = !busy && (ctrl_wr || rst_wr);
  assign ov_evt  = ov_tgl_s ^ ov_prev_q;
  assign clr_hit = wr && (addr == A_IRQCLR) && wdata[0];

  always_comb begin
    ctrl_d       = ctrl_q;
    period_d     = period_q;
    presc_d      = presc_q;
    cmd_ctrl_d   = cmd_ctrl_q;
    cmd_period_d = cmd_period_q;
    cmd_presc_d  = cmd_presc_q;
    req_d        = req_q;
    irq_en_d     = irq_en_q;
    if (fire && ctrl_wr) ctrl_d = wdata[CTRL_W-1:0];
    if (wr && addr == A_PERIOD) period_d = wdata[CNT_W-1:0];
    if (wr && addr == A_PRESC)  presc_d  = wdata[PRE_W-1:0];
    if (wr && addr == A_IRQEN)  irq_en_d = wdata[0];
    if (fire) begin
      // snapshot stays frozen until the acknowledge returns
      cmd_ctrl_d   = ctrl_d;
      cmd_period_d = period_q;
      cmd_presc_d  = presc_q;
      req_d        = ~req_q;
    end
    // a new event outranks a clear in the same cycle
    irq_st_d = ov_evt | (irq_st_q & ~clr_hit);
    irq_d    = irq_st_d & irq_en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q       <= '0;
      period_q     <= '0;
      presc_q      <= '0;
      cmd_ctrl_q   <= '0;
      cmd_period_q <= '0;
      cmd_presc_q  <= '0;
      req_q        <= 1'b0;
      ov_prev_q    <= 1'b0;
      irq_st_q     <= 1'b0;
      irq_en_q     <= 1'b0;
      irq_q        <= 1'b0;
    end else begin
      ctrl_q       <= ctrl_d;
      period_q     <= period_d;
      presc_q      <= presc_d;
      cmd_ctrl_q   <= cmd_ctrl_d;
      cmd_period_q <= cmd_period_d;
      cmd_presc_q  <= cmd_presc_d;
      req_q        <= req_d;
      ov_prev_q    <= ov_tgl_s;
      irq_st_q     <= irq_st_d;
      irq_en_q     <= irq_en_d;
      irq_q        <= irq_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:   rdata[CTRL_W-1:0] = ctrl_q;
      A_PERIOD: rdata[CNT_W-1:0]  = period_q;
      A_PRESC:  rdata[PRE_W-1:0]  = presc_q;
      A_IRQEN:  rdata[0]          = irq_en_q;
      A_STATUS: rdata[1:0]        = {busy, irq_st_q};
      default:  rdata = '0;
    endcase
  end

  assign req_tgl    = req_q;
  assign cmd_ctrl   = cmd_ctrl_q;
  assign cmd_period = cmd_period_q;
  assign cmd_presc  = cmd_presc_q;
  assign ctrl_rb    = ctrl_q;
  assign irq_status = irq_st_q;
  assign irq_en     = irq_en_q;
  assign irq        = irq_q;
endmodule

// File: rtl/wdk_core.sv
`timescale 1ns/1ps
// Safe-domain prescaler, timeout counter and command receiver
module wdk_core
  import keyed_wdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_tgl_s,
  input  wdt_ctrl_t        cmd_ctrl,
  input  logic [CNT_W-1:0] cmd_period,
  input  logic [PRE_W-1:0] cmd_presc,
  input  logic             halt_s,
  output logic             ack_tgl,
  output logic             ov_tgl,
  output logic             rst_req,
  output logic             load,
  output wdt_ctrl_t        ctrl_s,
  output logic [CNT_W-1:0] cnt,
  output logic [PRE_W-1:0] presc
);
  logic             req_prev_q;
  wdt_ctrl_t        ctrl_q, ctrl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_rl_q, cnt_rl_d;
  logic [PRE_W-1:0] pre_q, pre_d, pre_rl_q, pre_rl_d;
  logic             rst_q, rst_d;
  logic             ov_q, ov_d;
  logic             run, pre_zero, cnt_zero, tmo;

  // cmd_* are held stable by the bus side while the toggle is in flight
  assign load     = req_tgl_s ^ req_prev_q;
  assign run      = ctrl_q.en && !(ctrl_q.pause && halt_s);
  assign pre_zero = (pre_q == '0);
  assign cnt_zero = (cnt_q == '0);
  assign tmo      = !load && run && pre_zero && cnt_zero;

  always_comb begin
    ctrl_d   = ctrl_q;
    cnt_d    = cnt_q;
    pre_d    = pre_q;
    cnt_rl_d = cnt_rl_q;
    pre_rl_d = pre_rl_q;
    if (load) begin
      ctrl_d   = cmd_ctrl;
      cnt_d    = cmd_period;
      pre_d    = cmd_presc;
      cnt_rl_d = cmd_period;
      pre_rl_d = cmd_presc;
    end else if (run) begin
      if (pre_zero) begin
        pre_d = pre_rl_q;
        cnt_d = cnt_zero ? cnt_rl_q : cnt_q - CNT_W'(1);
      end else begin
        pre_d = pre_q - PRE_W'(1);
      end
    end
    rst_d = tmo && !ctrl_q.dbg;
    ov_d  = ov_q ^ (tmo && ctrl_q.dbg);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_prev_q <= 1'b0;
      ctrl_q     <= '0;
      cnt_q      <= '0;
      pre_q      <= '0;
      cnt_rl_q   <= '0;
      pre_rl_q   <= '0;
      rst_q      <= 1'b0;
      ov_q       <= 1'b0;
    end else begin
      req_prev_q <= req_tgl_s;
      ctrl_q     <= ctrl_d;
      cnt_q      <= cnt_d;
      pre_q      <= pre_d;
      cnt_rl_q   <= cnt_rl_d;
      pre_rl_q   <= pre_rl_d;
      rst_q      <= rst_d;
      ov_q       <= ov_d;
    end
  end

  assign ack_tgl = req_prev_q;
  assign ov_tgl  = ov_q;
  assign rst_req = rst_q;
  assign ctrl_s  = ctrl_q;
  assign cnt     = cnt_q;
  assign presc   = pre_q;
endmodule

// File: rtl/keyed_watchdog.sv
`timescale 1ns/1ps
// Watchdog top: bus-domain registers, safe-domain counters, crossings
module keyed_watchdog
  import keyed_wdt_pkg::*;
#(
  parameter int CNT_W     = 32,  // 1..32
  parameter int PRE_W     = 32,  // 1..32
  parameter int SYNC_STGS = 2
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  input  logic              safe_clk,
  input  logic              safe_rst_n,
  input  logic              dbg_halt,
  output logic              rst_req
);
  logic             req_tgl, req_tgl_s, ack_tgl, ack_tgl_s;
  logic             ov_tgl, ov_tgl_s, halt_s;
  wdt_ctrl_t        cmd_ctrl, ctrl_rb, ctrl_s;
  logic [CNT_W-1:0] cmd_period, cnt_s;
  logic [PRE_W-1:0] cmd_presc, presc_s;
  logic             irq_status, irq_en, ov_evt, clr_hit, load_s;

  wdk_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
    .clk(bus_clk), .rst_n(bus_rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .ack_tgl_s(ack_tgl_s),
    .ov_tgl_s(ov_tgl_s), .req_tgl(req_tgl), .cmd_ctrl(cmd_ctrl),
    .cmd_period(cmd_period), .cmd_presc(cmd_presc), .ctrl_rb(ctrl_rb),
    .irq_status(irq_status), .irq_en(irq_en), .ov_evt(ov_evt),
    .clr_hit(clr_hit), .irq(irq)
  );

  wdk_sync #(.STAGES(SYNC_STGS)) u_req_sync  (.clk(safe_clk), .rst_n(safe_rst_n), .d(req_tgl),  .q(req_tgl_s));
  wdk_sync #(.STAGES(SYNC_STGS)) u_halt_sync (.clk(safe_clk), .rst_n(safe_rst_n), .d(dbg_halt), .q(halt_s));
  wdk_sync #(.STAGES(SYNC_STGS)) u_ack_sync  (.clk(bus_clk),  .rst_n(bus_rst_n),  .d(ack_tgl),  .q(ack_tgl_s));
  wdk_sync #(.STAGES(SYNC_STGS)) u_ov_sync   (.clk(bus_clk),  .rst_n(bus_rst_n),  .d(ov_tgl),   .q(ov_tgl_s));

  wdk_core #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_core (
    .clk(safe_clk), .rst_n(safe_rst_n), .req_tgl_s(req_tgl_s),
    .cmd_ctrl(cmd_ctrl), .cmd_period(cmd_period), .cmd_presc(cmd_presc),
    .halt_s(halt_s), .ack_tgl(ack_tgl), .ov_tgl(ov_tgl), .rst_req(rst_req),
    .load(load_s), .ctrl_s(ctrl_s), .cnt(cnt_s), .presc(presc_s)
  );
endmodule

// File: rtl/wdk_checker.sv
`timescale 1ns/1ps
module wdk_checker
  import keyed_wdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 32
) (
  input logic              bus_clk,
  input logic              bus_rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input wdt_ctrl_t         ctrl_rb,
  input logic              irq_status,
  input logic              irq_en,
  input logic              ov_evt,
  input logic              clr_hit,
  input logic              irq,
  input logic              safe_clk,
  input logic              safe_rst_n,
  input logic              load,
  input wdt_ctrl_t         ctrl_s,
  input logic              halt_s,
  input logic [CNT_W-1:0]  cnt,
  input logic [PRE_W-1:0]  presc,
  input logic              rst_req
);
  // R3
  bad_key_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (bus_wr && bus_addr == A_CTRL && bus_wdata[DATA_W-1 -: KEY_W] != CTRL_KEY) |=> $stable(ctrl_rb));
  // R4
  irq_gate_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    irq |-> irq_en);
  // R5
  set_wins_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (ov_evt && clr_hit) |=> irq_status);
  // R5
  clear_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (clr_hit && !ov_evt) |=> !irq_status);
  // R4
  dbg_no_rst_chk: assert property (@(posedge safe_clk) disable iff (!safe_rst_n)
    ctrl_s.dbg |=> !rst_req);
  // R6
  pause_hold_chk: assert property (@(posedge safe_clk) disable iff (!safe_rst_n)
    (ctrl_s.pause && halt_s && !load) |=> ($stable(cnt) && $stable(presc)));
  // R8
  idle_hold_chk: assert property (@(posedge safe_clk) disable iff (!safe_rst_n)
    (!ctrl_s.en && !load) |=> ($stable(cnt) && $stable(presc) && !rst_req));
endmodule

bind keyed_watchdog wdk_checker #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (
  .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ctrl_rb(ctrl_rb),
  .irq_status(irq_status), .irq_en(irq_en), .ov_evt(ov_evt),
  .clr_hit(clr_hit), .irq(irq), .safe_clk(safe_clk),
  .safe_rst_n(safe_rst_n), .load(load_s), .ctrl_s(ctrl_s),
  .halt_s(halt_s), .cnt(cnt_s), .presc(presc_s), .rst_req(rst_req)
);

// File: tb/keyed_watchdog_tb.sv
`timescale 1ns/1ps
module keyed_watchdog_tb;
  import keyed_wdt_pkg::*;

  logic              bus_clk = 1'b0;
  logic              safe_clk = 1'b0;
  logic              bus_rst_n = 1'b0;
  logic              safe_rst_n = 1'b0;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              irq;
  logic              dbg_halt = 1'b0;
  logic              rst_req;

  always #2.5 safe_clk = ~safe_clk;  // 200 MHz
  always #3.5 bus_clk  = ~bus_clk;

  keyed_watchdog u_dut (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .safe_clk(safe_clk), .safe_rst_n(safe_rst_n),
    .dbg_halt(dbg_halt), .rst_req(rst_req)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // scoreboard: expected spacing between successive reset pulses
  typedef struct {
    longint ivl;
    string  rq;
  } exp_t;
  exp_t   exp_q[$];
  longint scyc = 0;
  longint last_pulse = 0;
  int     pulses = 0;
  logic   prev_rst = 1'b0;

  always @(posedge safe_clk) scyc++;

  always @(negedge safe_clk) begin
    exp_t e;
    if (rst_req) begin
      pulses++;
      if (prev_rst) chk(1'b0, "R2 pulse width", 2, 1);
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        chk(scyc - last_pulse == e.ivl, e.rq, scyc - last_pulse, e.ivl);
      end
      last_pulse = scyc;
    end
    prev_rst = rst_req;
  end

  task automatic push_exp(input longint ivl, input string rq);
    exp_t e;
    e.ivl = ivl;
    e.rq  = rq;
    exp_q.push_back(e);
  endtask

  function automatic logic [31:0] ckey(input logic [2:0] b);
    return {CTRL_KEY, 5'b0, b};
  endfunction

  task automatic bwrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge bus_clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge bus_clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge bus_clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    int n = 0;
    do begin
      bread(A_STATUS, s);
      n++;
    end while (s[1] && n < 200);
    chk(!s[1], "R7 busy clears", s[1], 0);
  endtask

  task automatic wait_safe(input int n);
    repeat (n) @(negedge safe_clk);
  endtask

  task automatic wait_pulse(input int lim, input string rq);
    int p0 = pulses;
    int n = 0;
    while (pulses == p0 && n < lim) begin
      @(negedge safe_clk);
      n++;
    end
    chk(pulses != p0, rq, pulses - p0, 1);
  endtask

  task automatic run_tests();
    logic [31:0] rd;
    int p0;
    int cfg_p[3] = '{1, 4, 0};
    int cfg_n[3] = '{3, 0, 6};

    // R9 reset state
    chk(rst_req == 1'b0, "R9 rst_req after reset", rst_req, 0);
    chk(irq == 1'b0, "R9 irq after reset", irq, 0);
    bread(A_CTRL, rd);   chk(rd == 0, "R9 ctrl after reset", rd, 0);
    bread(A_STATUS, rd); chk(rd == 0, "R9 status after reset", rd, 0);
    bread(A_PERIOD, rd); chk(rd == 0, "R9 period after reset", rd, 0);

    // R3 wrong key: no readback change, no command, no pulses
    bwrite(A_CTRL, {24'h123456, 5'b0, 3'b001});
    bread(A_STATUS, rd); chk(rd[1] == 1'b0, "R3 bad key starts no command", rd[1], 0);
    bread(A_CTRL, rd);   chk(rd == 0, "R3 bad key ctrl unchanged", rd, 0);
    wait_safe(200);
    chk(pulses == 0, "R3 bad key timer idle", pulses, 0);

    // R1 three timeout shapes
    for (int i = 0; i < 3; i++) begin
      bwrite(A_PERIOD, cfg_n[i]);
      bwrite(A_PRESC, cfg_p[i]);
      bwrite(A_CTRL, ckey(3'b001));
      bread(A_PERIOD, rd); chk(rd == cfg_n[i], "R9 period readback", rd, cfg_n[i]);
      bread(A_PRESC, rd);  chk(rd == cfg_p[i], "R9 presc readback", rd, cfg_p[i]);
      wait_idle();
      wait_pulse(500, "R1 first pulse");
      push_exp((cfg_p[i] + 1) * (cfg_n[i] + 1), "R1 interval");
      push_exp((cfg_p[i] + 1) * (cfg_n[i] + 1), "R1 interval");
      wait_pulse(500, "R1 pulse");
      wait_pulse(500, "R1 pulse");
      chk(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);
    end

    // R3 wrong key while running keeps the timer going
    bwrite(A_CTRL, {24'hC3A95F, 5'b0, 3'b000});
    bread(A_CTRL, rd); chk(rd == 1, "R3 bad key keeps enable", rd, 1);
    wait_pulse(500, "R3 pulses continue");

    // R7 busy window drops a second command
    bwrite(A_RESTART, 32'h0);
    bread(A_STATUS, rd); chk(rd[1] == 1'b1, "R7 busy after restart", rd[1], 1);
    bwrite(A_CTRL, ckey(3'b011));
    bread(A_CTRL, rd); chk(rd == 1, "R7 write while busy dropped", rd, 1);
    wait_idle();

    // R2 restarts hold off the reset request
    bwrite(A_PERIOD, 20);
    bwrite(A_PRESC, 2);
    bwrite(A_CTRL, ckey(3'b001));
    wait_idle();
    p0 = pulses;
    for (int k = 0; k < 10; k++) begin
      bwrite(A_RESTART, 32'h0);
      repeat (18) @(negedge bus_clk);
    end
    chk(pulses == p0, "R2 restarts prevent reset", pulses - p0, 0);
    wait_pulse(200, "R2 pulse after restarts stop");

    // R6 pause with halt stretches the interval by the halted cycles
    bwrite(A_PERIOD, 3);
    bwrite(A_PRESC, 1);
    bwrite(A_CTRL, ckey(3'b011));
    wait_idle();
    wait_pulse(200, "R6 first pulse");
    push_exp(8 + 20, "R6 paused interval");
    wait_safe(1);
    dbg_halt = 1'b1;
    wait_safe(20);
    dbg_halt = 1'b0;
    wait_pulse(200, "R6 pulse after pause");
    chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);

    // R6 halt without pause has no effect
    bwrite(A_CTRL, ckey(3'b001));
    wait_idle();
    wait_pulse(200, "R6 first pulse no pause");
    push_exp(8, "R6 halt ignored without pause");
    wait_safe(1);
    dbg_halt = 1'b1;
    wait_safe(20);
    dbg_halt = 1'b0;
    wait_pulse(200, "R6 pulse no pause");

    // R8 disabled timer stays silent
    bwrite(A_CTRL, ckey(3'b000));
    wait_idle();
    p0 = pulses;
    wait_safe(300);
    chk(pulses == p0, "R8 no pulse when disabled", pulses - p0, 0);

    // R4 debug mode: interrupt in place of reset
    bwrite(A_PERIOD, 9);
    bwrite(A_PRESC, 3);
    bwrite(A_CTRL, ckey(3'b101));
    wait_idle();
    p0 = pulses;
    wait_safe(300);
    chk(pulses == p0, "R4 no reset in debug mode", pulses - p0, 0);
    bread(A_STATUS, rd); chk(rd[0] == 1'b1, "R4 status set by timeout", rd[0], 1);
    chk(irq == 1'b0, "R4 irq masked", irq, 0);
    bwrite(A_IRQEN, 32'h1);
    @(negedge bus_clk);
    chk(irq == 1'b1, "R4 irq when enabled", irq, 1);

    // R5 clear writes on every cycle across several timeouts
    @(negedge bus_clk);
    bus_wr = 1'b1; bus_addr = A_IRQCLR; bus_wdata = 32'h1;
    repeat (80) @(negedge bus_clk);
    bus_wr = 1'b0;
    wait_safe(100);
    bread(A_STATUS, rd); chk(rd[0] == 1'b1, "R5 later event sets status", rd[0], 1);
    bwrite(A_CTRL, ckey(3'b100));
    wait_idle();
    wait_safe(20);
    bwrite(A_IRQCLR, 32'h1);
    bread(A_STATUS, rd); chk(rd[0] == 1'b0, "R5 clear empties status", rd[0], 0);
    chk(irq == 1'b0, "R5 irq low after clear", irq, 0);
  endtask

  initial begin
    repeat (4) @(negedge bus_clk);
    bus_rst_n  = 1'b1;
    @(negedge safe_clk);
    safe_rst_n = 1'b1;
    repeat (2) @(negedge bus_clk);
    fork
      run_tests();
      begin
        #900_000;
        chk(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule